// File: doc/BRIEF.md
# Mailbox Request Sequencer

This block is the requesting side of a 256-bit shared mailbox that holds eight 32-bit words. Word 7 is the header word, and its top bit shows which side owns the mailbox. On a start pulse the block carries out one of two commands: open (bring a queue set up) or close (tear it down).

Before it sends anything, the sequencer polls the header word until it owns the mailbox. An open command then checks four queue base addresses and an interrupt vector number. It packs their page frame numbers into the message and writes all eight words. A close command writes only the header word. The mailbox hands ownership to the responder when word 7 is written. The block then polls again until it gets ownership back and checks the response header. Each command ends with exactly one result pulse: done, timeout, parameter error or protocol error.

The poll spacing and the attempt limit are parameters given in clock cycles. The request version and the address geometry are parameters too.

Top module: `mbox_req_seq`

## Requirements
- R1: A start pulse is taken only while `busy` is low. `busy` is high from the cycle after the accepting edge until the result pulse. A start pulse while busy changes neither the command in flight nor its writes.
- R2: Before any write, the header word is sampled once every POLL_GAP+1 cycles. The first write follows the first sample in which header bit 31 reads 0.
- R3: If POLL_LIMIT samples in a row find bit 31 set, `err_timeout` pulses and nothing is written. With the first sample on the edge after the start edge, the pulse is visible 2+(POLL_LIMIT-1)*(POLL_GAP+1) cycles after the start edge. This holds also when the reset flag is set and the word reads all ones.
- R4: In an open command, `err_param` pulses and nothing is written if either of these is true: any address has a nonzero bit below PAGE_SHIFT, or the vector is 2^16 or larger.
- R5: The open message is built from the frame numbers (address >> PAGE_SHIFT, 52 bits). Message bits [48k+47:48k] hold the low 48 bits of frame k, with k = 0..3 for the four addresses in order. Bits [207:192] hold the high nibbles, frame k in bits [192+4k+3:192+4k]. Bits [223:208] hold the vector. Word i is message bits [32i+31:32i].
- R6: The request header has these fields: type in bits [2:0] (1 = open, 2 = close), REQ_VERSION in [5:3], direction bit 7 = 0, status [15:8] = 0, reset flag in bit 24, and all other bits 0.
- R7: An open command writes words 0 through 7 on consecutive cycles. A close command writes only word 7.
- R8: After the header write, the block samples the header word every POLL_GAP+1 cycles. A free word (bit 31 = 0) with a matching type, direction 1 and status 0 gives `done`, visible 1 to POLL_GAP+1 cycles after the response appears.
- R9: A response version lower than or equal to REQ_VERSION is accepted.
- R10: A free response is a protocol error (`err_proto`) if any of these holds: its type differs from the request, its version is above REQ_VERSION, its direction is 0, or its status is nonzero.
- R11: With the reset flag set, a response word of 0xFFFFFFFF ends the wait with `done`. With the flag clear, the same word counts as still owned and the wait ends in `err_timeout`.
- R12: Each command yields exactly one single-cycle result pulse, and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Command start pulse |
| cmd_close | input | 1 | 0 = open, 1 = close |
| reset_mode | input | 1 | Reset flag sent in the header |
| addr_eq | input | ADDR_W | Event queue base address |
| addr_cq | input | ADDR_W | Completion queue base address |
| addr_rq | input | ADDR_W | Receive queue base address |
| addr_sq | input | ADDR_W | Send queue base address |
| vector | input | VEC_W | Interrupt vector number |
| hdr_word | input | 32 | Current mailbox header word |
| mb_wr_en | output | 1 | Mailbox word write strobe |
| mb_wr_idx | output | 3 | Word index being written |
| mb_wr_data | output | 32 | Word data being written |
| busy | output | 1 | Command in flight |
| done | output | 1 | Success pulse |
| err_timeout | output | 1 | Poll limit exhausted pulse |
| err_param | output | 1 | Bad address or vector pulse |
| err_proto | output | 1 | Bad response pulse |

## Verification
The first header sample falls on the edge after the start edge, and later samples come every POLL_GAP+1 edges. The result pulses are registered, so a result shows one cycle after its deciding sample. This gives a timeout an exact due cycle, which the bench checks by counting falling edges from the start pulse. A release of ownership or a response can land anywhere in the sampling interval. For those cases the bench checks the first write, or the done pulse, against the window of one to POLL_GAP+1 cycles. It drives inputs and reads outputs 1 ns after each falling edge. Its mailbox model stores each write on that falling edge and sets bit 31 when it stores word 7.

// File: rtl/mbox_req_pkg.sv
package mbox_req_pkg;

  localparam int WORD_W    = 32;
  localparam int MSG_WORDS = 8;
  localparam int MSG_W     = WORD_W * MSG_WORDS;
  localparam int LOW_W     = 48;
  localparam int HIGH_W    = 4;
  localparam int FRAME_W   = LOW_W + HIGH_W;
  localparam int NUM_ADDR  = 4;
  localparam int VEC_FIELD = 16;
  localparam logic [2:0] HDR_IDX    = 3'd7;
  localparam logic [2:0] TYPE_OPEN  = 3'd1;
  localparam logic [2:0] TYPE_CLOSE = 3'd2;

  // Header layout, MSB first: owner, reserved, reset flag, reserved, status,
  // direction, reserved, version, type.
  typedef struct packed {
    logic       owner;
    logic [5:0] rsv_hi;
    logic       rst_flag;
    logic [7:0] rsv_mid;
    logic [7:0] status;
    logic       dir;
    logic       rsv_lo;
    logic [2:0] ver;
    logic [2:0] mtype;
  } hdr_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRE   = 2'd1,
    ST_WRITE = 2'd2,
    ST_POST  = 2'd3
  } seq_state_e;

  function automatic hdr_t make_request(input logic [2:0] mtype,
                                        input logic [2:0] ver,
                                        input logic rst_flag);
    hdr_t h;
    h          = '0;
    h.mtype    = mtype;
    h.ver      = ver;
    h.rst_flag = rst_flag;
    return h;
  endfunction

  function automatic logic response_good(input hdr_t h,
                                         input logic [2:0] exp_type,
                                         input logic [2:0] exp_ver);
    return (h.mtype == exp_type) && (h.ver <= exp_ver) &&
           h.dir && (h.status == 8'd0);
  endfunction

endpackage

// File: rtl/mbox_poll_timer.sv
module mbox_poll_timer #(
  parameter int GAP   = 4,
  parameter int LIMIT = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic hit,
  output logic attempt,
  output logic expired
);
  localparam int GAP_W = $clog2(GAP + 2);
  localparam int TRY_W = $clog2(LIMIT + 1);

  logic [GAP_W-1:0] gap_q;
  logic [TRY_W-1:0] try_q;

  assign attempt = run && (gap_q == '0);
  assign expired = attempt && !hit && (try_q == TRY_W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
      try_q <= '0;
    end else if (!run) begin
      gap_q <= '0;
      try_q <= '0;
    end else if (attempt && !hit) begin
      gap_q <= GAP_W'(GAP);
      try_q <= try_q + 1'b1;
    end else if (gap_q != '0) begin
      gap_q <= gap_q - 1'b1;
    end
  end

  // R3: attempt count never passes the limit
  a_r3_try_bound: assert property (@(posedge clk) disable iff (!rst_n)
    try_q <= TRY_W'(LIMIT));

  generate
    if (GAP > 0) begin : g_gap
      // R2: a failed sample is followed by a quiet cycle
      a_r2_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (attempt && !hit) |=> !attempt);
    end
  endgenerate

endmodule

// File: rtl/mbox_msg_pack.sv
module mbox_msg_pack
  import mbox_req_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int PAGE_SHIFT = 12,
  parameter int VEC_W      = 32
) (
  input  logic [NUM_ADDR-1:0][ADDR_W-1:0] addrs,
  input  logic [VEC_W-1:0]                vec,
  input  hdr_t                            hdr,
  output logic [MSG_W-1:0]                msg,
  output logic                            params_ok
);
  localparam int NIB_BASE = NUM_ADDR * LOW_W;
  localparam int VEC_BASE = NIB_BASE + NUM_ADDR * HIGH_W;
  localparam int HDR_BASE = VEC_BASE + VEC_FIELD;

  logic [NUM_ADDR-1:0] aligned;
  logic [NUM_ADDR*HIGH_W-1:0] nibbles;

  generate
    for (genvar k = 0; k < NUM_ADDR; k++) begin : g_addr
      logic [FRAME_W-1:0] frame;
      assign frame   = FRAME_W'(addrs[k] >> PAGE_SHIFT);
      assign aligned[k] = (addrs[k][PAGE_SHIFT-1:0] == '0);
      assign msg[LOW_W*k +: LOW_W]     = frame[LOW_W-1:0];
      assign nibbles[HIGH_W*k +: HIGH_W] = frame[FRAME_W-1:LOW_W];
    end
  endgenerate

  assign msg[NIB_BASE +: NUM_ADDR*HIGH_W] = nibbles;
  assign msg[VEC_BASE +: VEC_FIELD]       = vec[VEC_FIELD-1:0];
  assign msg[HDR_BASE +: WORD_W]          = hdr;
  assign params_ok = (&aligned) && ((vec >> VEC_FIELD) == '0);

endmodule

// File: rtl/mbox_resp_check.sv
module mbox_resp_check
  import mbox_req_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [2:0]        exp_type,
  input  logic [2:0]        exp_ver,
  input  logic              reset_mode,
  output logic              free_now,
  output logic              reset_ack,
  output logic              resp_good
);
  hdr_t h;
  assign h         = word;
  assign free_now  = !h.owner;
  assign reset_ack = reset_mode && (&word);
  assign resp_good = response_good(h, exp_type, exp_ver);
endmodule

// File: rtl/mbox_req_seq.sv
module mbox_req_seq
  import mbox_req_pkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int PAGE_SHIFT  = 12,
  parameter int VEC_W       = 32,
  parameter int POLL_GAP    = 100000,
  parameter int POLL_LIMIT  = 20000,
  parameter int REQ_VERSION = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cmd_close,
  input  logic              reset_mode,
  input  logic [ADDR_W-1:0] addr_eq,
  input  logic [ADDR_W-1:0] addr_cq,
  input  logic [ADDR_W-1:0] addr_rq,
  input  logic [ADDR_W-1:0] addr_sq,
  input  logic [VEC_W-1:0]  vector,
  input  logic [31:0]       hdr_word,
  output logic              mb_wr_en,
  output logic [2:0]        mb_wr_idx,
  output logic [31:0]       mb_wr_data,
  output logic              busy,
  output logic              done,
  output logic              err_timeout,
  output logic              err_param,
  output logic              err_proto
);
  localparam logic [2:0] REQ_VER = 3'(REQ_VERSION);

  seq_state_e state_q;
  logic       close_q, rflag_q;
  logic [NUM_ADDR-1:0][ADDR_W-1:0] addrs_q;
  logic [VEC_W-1:0] vec_q;
  logic [2:0] idx_q;
  logic done_q, tout_q, param_q, proto_q;

  logic [2:0] req_type;
  hdr_t       req_hdr;
  logic [MSG_W-1:0] msg;
  logic params_ok;
  logic free_now, reset_ack, resp_good;
  logic poll_run, poll_hit, attempt, expired;

  // named internal events
  logic pre_grant, post_accept, post_reject, last_write;

  assign req_type = close_q ? TYPE_CLOSE : TYPE_OPEN;
  assign req_hdr  = make_request(req_type, REQ_VER, rflag_q);

  mbox_msg_pack #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .VEC_W(VEC_W)
  ) u_pack (
    .addrs(addrs_q), .vec(vec_q), .hdr(req_hdr),
    .msg(msg), .params_ok(params_ok)
  );

  mbox_resp_check u_resp (
    .word(hdr_word), .exp_type(req_type), .exp_ver(REQ_VER),
    .reset_mode(rflag_q), .free_now(free_now),
    .reset_ack(reset_ack), .resp_good(resp_good)
  );

  assign poll_run = (state_q == ST_PRE) || (state_q == ST_POST);
  assign poll_hit = (state_q == ST_PRE) ? free_now : (free_now || reset_ack);

  mbox_poll_timer #(.GAP(POLL_GAP), .LIMIT(POLL_LIMIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(poll_run), .hit(poll_hit),
    .attempt(attempt), .expired(expired)
  );

  assign pre_grant   = (state_q == ST_PRE)  && attempt && free_now;
  assign post_accept = (state_q == ST_POST) && attempt &&
                       (reset_ack || (free_now && resp_good));
  assign post_reject = (state_q == ST_POST) && attempt && !reset_ack &&
                       free_now && !resp_good;
  assign last_write  = (state_q == ST_WRITE) && (idx_q == HDR_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      close_q <= 1'b0;
      rflag_q <= 1'b0;
      addrs_q <= '0;
      vec_q   <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
      tout_q  <= 1'b0;
      param_q <= 1'b0;
      proto_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      tout_q  <= 1'b0;
      param_q <= 1'b0;
      proto_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) begin
          close_q <= cmd_close;
          rflag_q <= reset_mode;
          addrs_q <= {addr_sq, addr_rq, addr_cq, addr_eq};
          vec_q   <= vector;
          state_q <= ST_PRE;
        end
        ST_PRE: begin
          if (pre_grant) begin
            if (!close_q && !params_ok) begin
              param_q <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              idx_q   <= close_q ? HDR_IDX : 3'd0;
              state_q <= ST_WRITE;
            end
          end else if (expired) begin
            tout_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_WRITE: begin
          idx_q <= idx_q + 3'd1;
          if (last_write) state_q <= ST_POST;
        end
        ST_POST: begin
          if (post_accept) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (post_reject) begin
            proto_q <= 1'b1;
            state_q <= ST_IDLE;
          end else if (expired) begin
            tout_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mb_wr_en    = (state_q == ST_WRITE);
  assign mb_wr_idx   = idx_q;
  assign mb_wr_data  = msg[idx_q*WORD_W +: WORD_W];
  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign err_timeout = tout_q;
  assign err_param   = param_q;
  assign err_proto   = proto_q;

  // R1: an accepted start makes the block busy on the next cycle
  a_r1_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R2: the first write comes only after a free header sample
  a_r2_write_after_free: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_wr_en && !$past(mb_wr_en)) |-> $past(hdr_word[31] == 1'b0));

  // R6: the header word leaves with request direction, zero status, free owner
  a_r6_hdr_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_wr_en && mb_wr_idx == HDR_IDX) |->
      (mb_wr_data[31] == 1'b0 && mb_wr_data[7] == 1'b0 &&
       mb_wr_data[15:8] == 8'd0 && mb_wr_data[5:3] == REQ_VER));

  // R7: writes advance one index per cycle up to the header word
  a_r7_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_wr_en && mb_wr_idx != HDR_IDX) |=>
      (mb_wr_en && mb_wr_idx == $past(mb_wr_idx) + 3'd1));

  // R12: at most one result at a time, and never while busy
  a_r12_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err_timeout, err_param, err_proto}));
  a_r12_result_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err_timeout || err_param || err_proto) |-> !busy);

endmodule

// File: tb/mbox_req_seq_tb_top.sv
module mbox_req_seq_tb_top;
  localparam int GAP = 3;
  localparam int LIM = 6;
  localparam int VER = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, cmd_close, reset_mode;
  logic [63:0] a_eq, a_cq, a_rq, a_sq;
  logic [31:0] vector, hdr_word;
  logic mb_wr_en, busy, done, err_timeout, err_param, err_proto;
  logic [2:0] mb_wr_idx;
  logic [31:0] mb_wr_data;

  logic [31:0] mem [8];
  assign hdr_word = mem[7];

  mbox_req_seq #(.ADDR_W(64), .PAGE_SHIFT(12), .VEC_W(32), .POLL_GAP(GAP),
                 .POLL_LIMIT(LIM), .REQ_VERSION(VER)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_close(cmd_close),
    .reset_mode(reset_mode), .addr_eq(a_eq), .addr_cq(a_cq), .addr_rq(a_rq),
    .addr_sq(a_sq), .vector(vector), .hdr_word(hdr_word),
    .mb_wr_en(mb_wr_en), .mb_wr_idx(mb_wr_idx), .mb_wr_data(mb_wr_data),
    .busy(busy), .done(done), .err_timeout(err_timeout),
    .err_param(err_param), .err_proto(err_proto));

  int cyc = 0, wcount = 0, n_chk = 0, n_fail = 0;
  int widx [16];
  int wcyc [16];
  logic [31:0] wdata [16];
  bit hdr_written;

  // mailbox model: stores writes; storing word 7 hands ownership over
  always @(negedge clk) begin
    cyc++;
    if (mb_wr_en) begin
      if (wcount < 16) begin
        widx[wcount] = int'(mb_wr_idx);
        wdata[wcount] = mb_wr_data;
        wcyc[wcount] = cyc;
      end
      wcount++;
      if (mb_wr_idx == 3'd7) begin
        mem[7] = mb_wr_data | 32'h8000_0000;
        hdr_written = 1'b1;
      end else begin
        mem[mb_wr_idx] = mb_wr_data;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected words built byte by byte
  function automatic logic [31:0] exp_word(input int w, input bit close,
                                           input bit rf);
    logic [7:0] b [32];
    logic [63:0] ad [4];
    logic [63:0] fr;
    logic [15:0] nib;
    logic [31:0] h;
    ad[0] = a_eq; ad[1] = a_cq; ad[2] = a_rq; ad[3] = a_sq;
    nib = '0;
    for (int i = 0; i < 32; i++) b[i] = 8'h00;
    for (int k = 0; k < 4; k++) begin
      fr = ad[k] / 64'd4096;
      for (int j = 0; j < 6; j++) b[6*k+j] = fr[8*j +: 8];
      nib = nib | (16'(fr[51:48]) << (4*k));
    end
    b[24] = nib[7:0];  b[25] = nib[15:8];
    b[26] = vector[7:0]; b[27] = vector[15:8];
    h = (close ? 32'd2 : 32'd1) + 32'(VER) * 8 + (rf ? 32'h0100_0000 : 32'd0);
    for (int j = 0; j < 4; j++) b[28+j] = h[8*j +: 8];
    return {b[4*w+3], b[4*w+2], b[4*w+1], b[4*w]};
  endfunction

  // result codes: 1 done, 2 timeout, 3 param, 4 proto
  int res, pulses, res_k, rel_k, rsp_k, t0;
  bit busy_mid;

  task automatic run_cmd(input bit close, input bit rf, input logic [31:0] resp,
                         input int resp_delay, input int release_at,
                         input bit poke);
    int due;
    @(negedge clk); #1;
    for (int w = 0; w < 8; w++) mem[w] = 32'd0;
    mem[7] = (release_at == 0) ? 32'd0 : 32'h8000_0000;
    wcount = 0; hdr_written = 1'b0;
    cmd_close = close; reset_mode = rf; start = 1'b1; t0 = cyc;
    res = 0; pulses = 0; res_k = -1; rel_k = -1; rsp_k = -1; due = -1;
    busy_mid = 1'b0;
    @(negedge clk); #1;
    start = 1'b0;
    for (int k = 1; k <= 300; k++) begin
      if (k == 1) busy_mid = busy;
      pulses += int'(done) + int'(err_timeout) + int'(err_param) + int'(err_proto);
      if (res == 0 && (done || err_timeout || err_param || err_proto)) begin
        res = done ? 1 : err_timeout ? 2 : err_param ? 3 : 4;
        res_k = k;
        chk(!busy, "R12", "busy during result", 64'(busy), 64'd0);
      end
      if (res != 0 && k >= res_k + 3) break;
      if (release_at > 0 && k == release_at) begin mem[7] = 32'd0; rel_k = k; end
      if (poke && k == 3) begin start = 1'b1; cmd_close = ~close; end
      else if (poke && k == 4) start = 1'b0;
      if (resp_delay >= 0 && hdr_written && due < 0) due = k + resp_delay;
      if (k == due) begin mem[7] = resp; rsp_k = k; end
      @(negedge clk); #1;
    end
  endtask

  task automatic chk_writes(input string req, input bit close, input bit rf);
    int n;
    n = close ? 1 : 8;
    chk(wcount == n, req, "write count", 64'(wcount), 64'(n));
    for (int i = 0; i < n && i < wcount; i++) begin
      int ix;
      ix = close ? 7 : i;
      chk(widx[i] == ix, req, "write index", 64'(widx[i]), 64'(ix));
      chk(wdata[i] == exp_word(ix, close, rf), req, "write data",
          64'(wdata[i]), 64'(exp_word(ix, close, rf)));
      if (i > 0) chk(wcyc[i] == wcyc[i-1] + 1, "R7", "consecutive writes",
                     64'(wcyc[i] - wcyc[i-1]), 64'd1);
    end
  endtask

  task automatic t_reset;
    chk(busy == 0 && mb_wr_en == 0, "R1", "reset busy/wr", 64'({busy, mb_wr_en}), 64'd0);
    chk({done, err_timeout, err_param, err_proto} == 4'd0, "R12", "reset pulses",
        64'({done, err_timeout, err_param, err_proto}), 64'd0);
  endtask

  task automatic t_open_ok(input bit rf);
    run_cmd(1'b0, rf, 32'h0000_0091, 2, 0, 1'b0);
    chk(busy_mid, "R1", "busy after start", 64'(busy_mid), 64'd1);
    chk(res == 1, "R8", "open result", 64'(res), 64'd1);
    chk(pulses == 1, "R12", "pulse count", 64'(pulses), 64'd1);
    chk(res_k > rsp_k && res_k <= rsp_k + GAP + 1, "R8", "done latency",
        64'(res_k - rsp_k), 64'(GAP + 1));
    chk_writes("R5", 1'b0, rf);
    if (wcount == 8) chk(wdata[7][24] == rf, "R6", "reset flag bit", 64'(wdata[7][24]), 64'(rf));
  endtask

  task automatic t_close_ok;
    run_cmd(1'b1, 1'b0, 32'h0000_0092, 1, 0, 1'b0);
    chk(res == 1, "R8", "close result", 64'(res), 64'd1);
    chk_writes("R7", 1'b1, 1'b0);
    chk(wcount == 1 && wdata[0] == 32'(2 + VER * 8), "R6", "close header",
        64'(wdata[0]), 64'(2 + VER * 8));
  endtask

  task automatic t_resp(input logic [31:0] resp, input int exp_res, input string req);
    run_cmd(1'b0, 1'b0, resp, 1, 0, 1'b0);
    chk(res == exp_res, req, "response verdict", 64'(res), 64'(exp_res));
  endtask

  task automatic t_reset_ack;
    run_cmd(1'b1, 1'b1, 32'hFFFF_FFFF, 1, 0, 1'b0);
    chk(res == 1, "R11", "all-ones with flag", 64'(res), 64'd1);
    run_cmd(1'b1, 1'b0, 32'hFFFF_FFFF, 1, 0, 1'b0);
    chk(res == 2, "R11", "all-ones without flag", 64'(res), 64'd2);
  endtask

  task automatic t_param(input int which);
    logic [63:0] s;
    s = a_cq;
    if (which == 0) a_cq = a_cq | 64'h800; else vector = 32'h0001_0000;
    run_cmd(1'b0, 1'b0, 32'h91, 1, 0, 1'b0);
    chk(res == 3, "R4", "param verdict", 64'(res), 64'd3);
    chk(wcount == 0, "R4", "no writes", 64'(wcount), 64'd0);
    a_cq = s; vector = 32'h0000_1234;
  endtask

  task automatic t_pre_timeout;
    int due;
    due = 2 + (LIM - 1) * (GAP + 1);
    run_cmd(1'b0, 1'b1, 32'h91, -1, -1, 1'b0);
    mem[7] = 32'hFFFF_FFFF;
    chk(res == 2, "R3", "timeout verdict", 64'(res), 64'd2);
    chk(res_k == due, "R3", "timeout cycle", 64'(res_k), 64'(due));
    chk(wcount == 0, "R3", "no writes", 64'(wcount), 64'd0);
  endtask

  task automatic t_release;
    run_cmd(1'b0, 1'b0, 32'h91, 1, 7, 1'b0);
    chk(wcount > 0 && wcyc[0] - t0 > rel_k && wcyc[0] - t0 <= rel_k + GAP + 1,
        "R2", "first write after release", 64'(wcyc[0] - t0), 64'(rel_k + 1));
    chk(res == 1, "R2", "release result", 64'(res), 64'd1);
  endtask

  task automatic t_poke;
    run_cmd(1'b0, 1'b0, 32'h91, 3, 0, 1'b1);
    chk(res == 1 && pulses == 1, "R1", "second start ignored",
        64'(pulses), 64'd1);
    chk_writes("R1", 1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; cmd_close = 1'b0; reset_mode = 1'b0;
    a_eq = 64'hA123_4567_89AB_C000; a_cq = 64'h5FED_CBA9_8765_4000;
    a_rq = 64'h0000_0000_0000_1000; a_sq = 64'hFFFF_FFFF_FFFF_F000;
    vector = 32'h0000_1234;
    for (int w = 0; w < 8; w++) mem[w] = 32'd0;
    repeat (3) @(negedge clk);
    #1 t_reset();
    rst_n = 1'b1;
    t_open_ok(1'b0);
    a_eq = 64'h0003_0000_0000_0000; vector = 32'h0000_FFFF;
    t_open_ok(1'b1);
    vector = 32'h0000_1234;
    t_close_ok();
    t_resp(32'h0000_0089, 1, "R9");
    t_resp(32'h0000_0081, 1, "R9");
    t_resp(32'h0000_0099, 4, "R10");
    t_resp(32'h0000_0092, 4, "R10");
    t_resp(32'h0000_0011, 4, "R10");
    t_resp(32'h0000_0591, 4, "R10");
    t_reset_ack();
    t_param(0);
    t_param(1);
    t_pre_timeout();
    t_release();
    t_poke();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_900_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule